// File: doc/BRIEF.md
# Software Write-Protection Controller

This block sits behind the bit-level front end of a two-wire serial slave that fronts a 256-byte nonvolatile memory. For every byte of a write transaction or a protection command, it decides whether the slave drives an acknowledge. It also decides whether the closing stop condition starts a nonvolatile commit. The front end presents one decoded byte event at a time: the address space selected, the chip-enable levels, the byte position inside the transaction, the RW bit and the current target address. The controller answers one cycle later.

The controller holds a protection level for the lower half of the memory (addresses below 80h). There are three levels. Unlocked leaves the lower half writable. Soft lock protects it and can be undone with a clear command. Hard lock protects it and cannot be removed. Three protection commands move between the levels. A set command needs the high-voltage flag on the first enable pin, with the other two pins low. A clear command needs the high-voltage flag, with the top pin low and the middle pin high. A permanent-lock command needs a normal chip-enable match. The write-control pin, when high, blocks every data byte in every space.

A level change takes effect only when the memory reports that the commit has finished. Until that report arrives, the controller refuses every byte, which gives the host its acknowledge-polling behaviour. The reset value of the level is a parameter, so simulation can start from any stored state.

Top module: `wpGuard`

## Requirements
- R1: After reset, protState equals the PROT_INIT parameter and ackOut, ackValid and commitReq are low. The protState encoding is 00 for unlocked, 01 for soft lock and 10 for hard lock.
- R2: ackValid is high in the cycle after each byteValid cycle, and ackOut in that cycle carries the decision for that byte. In the memory space (protSpace=0) with ceMatch high, the select byte (bytePhase 0) and the address byte (bytePhase 1) are acknowledged. A data byte (bytePhase 2 or 3) of a write is acknowledged when wcLevel is low and the target is not protected. With ceMatch low, every byte is refused.
- R3: With wcLevel high, every data byte of a write form is refused, in both spaces, and the following stop produces no commit request.
- R4: While protState is not unlocked, a memory write data byte whose targetAddr has its top bit clear is refused. A data byte whose target has the top bit set is still acknowledged when wcLevel is low.
- R5: When unlocked, all three protection commands are acknowledged on the select, address and data bytes if wcLevel is low. With wcLevel high, the select and address bytes are acknowledged and the data byte is refused.
- R6: In soft lock, a set command is refused on every byte. Clear and permanent-lock commands are acknowledged on the select and address bytes, and on the data byte only when wcLevel is low.
- R7: In hard lock, every protection-space byte is refused whatever wcLevel is, no commit follows, and protState never leaves hard lock.
- R8: With rwBit high, the select byte follows the same acceptance rule as the write form of the same command, and every later byte gets ackOut low.
- R9: commitReq pulses for one cycle, in the cycle after stopSeen, only if the most recent data byte since the last select byte was acknowledged. A stop after only select and address bytes gives no pulse.
- R10: protState changes only in the cycle after a writeDone that closes a commit started by a protection command. A set moves it to soft lock, a clear to unlocked and a permanent lock to hard lock. It is unchanged at the stop, and unchanged by a writeDone with no commit outstanding.
- R11: From a commit request until the matching writeDone, every byte is refused and a stop produces no new commit request.
- R12: A protection-space byte whose pin pattern fits none of the three commands (for example, the high-voltage flag with the top enable pin high, or no high-voltage flag and no chip-enable match) is refused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| byteValid | input | 1 | One-cycle strobe: a received byte needs an acknowledge decision |
| bytePhase | input | 2 | Byte position: 0 select, 1 address, 2 or 3 data |
| protSpace | input | 1 | 1 when the select code named the protection space, 0 for memory |
| e2Level | input | 1 | Level of the top chip-enable pin |
| e1Level | input | 1 | Level of the middle chip-enable pin |
| e0HighV | input | 1 | High-voltage detected on the lowest chip-enable pin |
| ceMatch | input | 1 | Chip-enable bits of the select code match the pins |
| rwBit | input | 1 | RW bit of the current transaction, 1 for read |
| targetAddr | input | ADDR_W | Memory location the current data byte targets |
| wcLevel | input | 1 | Write-control pin level, 1 blocks all writes |
| stopSeen | input | 1 | One-cycle strobe on a stop condition |
| writeDone | input | 1 | One-cycle strobe when the nonvolatile commit has finished |
| ackValid | output | 1 | High in the cycle carrying a decision |
| ackOut | output | 1 | 1 to acknowledge the byte, 0 to refuse it |
| commitReq | output | 1 | One-cycle request to start the nonvolatile commit |
| protState | output | 2 | Protection level: 00 unlocked, 01 soft, 10 hard |

## Verification
The hardest situation to reach from the ports is hard lock, because it cannot be preset without the parameter. The bench first gets there legitimately: it issues a set command, lets the commit finish, tries a refused repeat set, clears, then issues a permanent lock and completes its commit. Only then does it sweep every protection command in both write and read form, at both write-control levels. The commit window is opened on purpose and probed with select bytes and a stray stop before writeDone closes it, so that refusals during the window and a level that holds through the stop can both be observed.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef enum logic [1:0] {
    LOCK_NONE = 2'b00,
    LOCK_SOFT = 2'b01,
    LOCK_HARD = 2'b10
  } lockState_t;

  typedef enum logic [1:0] {
    OP_MEM  = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_PERM = 2'd3
  } pendOp_t;

  // Control-to-datapath strobes for one clock.
  typedef struct packed {
    logic    ackLoad;   // a decision is produced this cycle
    logic    ackBit;    // the decision
    logic    armLoad;   // a write-form data byte was judged
    logic    armBit;    // that data byte was accepted
    pendOp_t armOp;     // what a commit would do
    logic    disarm;    // select byte or stop: forget the arming
    logic    fire;      // start a commit now
    logic    retire;    // commit finished, apply the pending operation
  } wpStrobe_t;

endpackage

// File: rtl/wpDecide.sv
module wpDecide
  import wp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              byteValid,
  input  logic [1:0]        bytePhase,
  input  logic              protSpace,
  input  logic              e2Level,
  input  logic              e1Level,
  input  logic              e0HighV,
  input  logic              ceMatch,
  input  logic              rwBit,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic              wcLevel,
  input  logic              stopSeen,
  input  logic              writeDone,
  input  lockState_t        lockQ,
  input  logic              armedQ,
  input  logic              busyQ,
  output wpStrobe_t         strobe
);

  localparam int TOP_BIT = ADDR_W - 1;

  logic    isSelect;
  logic    isAddress;
  logic    isData;
  logic    lowHalf;
  logic    cmdHit;
  pendOp_t cmdOp;
  logic    statusOk;
  logic    decision;

  assign isSelect  = (bytePhase == 2'd0);
  assign isAddress = (bytePhase == 2'd1);
  assign isData    = bytePhase[1];
  assign lowHalf   = ~targetAddr[TOP_BIT];

  // Which operation the current transaction names, and whether it names any.
  always_comb begin
    cmdHit = 1'b0;
    cmdOp  = OP_MEM;
    if (!protSpace) begin
      cmdHit = ceMatch;
      cmdOp  = OP_MEM;
    end else if (e0HighV) begin
      if (!e2Level) begin
        cmdHit = 1'b1;
        cmdOp  = e1Level ? OP_CLR : OP_SET;
      end
    end else if (ceMatch) begin
      cmdHit = 1'b1;
      cmdOp  = OP_PERM;
    end
  end

  // Whether the protection level lets this command through at all.
  always_comb begin
    statusOk = cmdHit;
    if (protSpace) begin
      unique case (lockQ)
        LOCK_HARD: statusOk = 1'b0;
        LOCK_SOFT: if (cmdOp == OP_SET) statusOk = 1'b0;
        default:   ;
      endcase
    end
  end

  always_comb begin
    decision = 1'b0;
    if (!busyQ && statusOk) begin
      if (isSelect) begin
        decision = 1'b1;
      end else if (!rwBit) begin
        if (isAddress) begin
          decision = 1'b1;
        end else if (!wcLevel) begin
          decision = protSpace | ~(lowHalf & (lockQ != LOCK_NONE));
        end
      end
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.ackLoad = byteValid;
    strobe.ackBit  = decision;
    strobe.armLoad = byteValid & ~busyQ & isData & ~rwBit;
    strobe.armBit  = decision;
    strobe.armOp   = cmdOp;
    strobe.disarm  = stopSeen | (byteValid & ~busyQ & isSelect);
    strobe.fire    = stopSeen & ~busyQ & armedQ;
    strobe.retire  = writeDone & busyQ;
  end

endmodule

// File: rtl/wpLockRegs.sv
module wpLockRegs
  import wp_pkg::*;
#(
  parameter logic [1:0] PROT_INIT = 2'b00
) (
  input  logic       clk,
  input  logic       rstN,
  input  wpStrobe_t  strobe,
  output lockState_t lockQ,
  output logic       armedQ,
  output logic       busyQ,
  output logic       ackValid,
  output logic       ackOut,
  output logic       commitReq
);

  localparam lockState_t LOCK_RST = lockState_t'(PROT_INIT);

  pendOp_t opQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackValid  <= 1'b0;
      ackOut    <= 1'b0;
      commitReq <= 1'b0;
    end else begin
      ackValid  <= strobe.ackLoad;
      ackOut    <= strobe.ackLoad & strobe.ackBit;
      commitReq <= strobe.fire;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
      opQ    <= OP_MEM;
    end else if (strobe.disarm) begin
      armedQ <= 1'b0;
    end else if (strobe.armLoad) begin
      armedQ <= strobe.armBit;
      opQ    <= strobe.armOp;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
    end else if (strobe.fire) begin
      busyQ <= 1'b1;
    end else if (strobe.retire) begin
      busyQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ <= LOCK_RST;
    end else if (strobe.retire && lockQ != LOCK_HARD) begin
      unique case (opQ)
        OP_SET:  lockQ <= LOCK_SOFT;
        OP_CLR:  lockQ <= LOCK_NONE;
        OP_PERM: lockQ <= LOCK_HARD;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/wpGuard.sv
module wpGuard
  import wp_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter logic [1:0] PROT_INIT = 2'b00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [1:0]        bytePhase,
  input  logic              protSpace,
  input  logic              e2Level,
  input  logic              e1Level,
  input  logic              e0HighV,
  input  logic              ceMatch,
  input  logic              rwBit,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic              wcLevel,
  input  logic              stopSeen,
  input  logic              writeDone,
  output logic              ackValid,
  output logic              ackOut,
  output logic              commitReq,
  output logic [1:0]        protState
);

  wpStrobe_t  strobe;
  lockState_t lockQ;
  logic       armedQ;
  logic       busyQ;

  wpDecide #(.ADDR_W(ADDR_W)) u_dec (
    .byteValid (byteValid),
    .bytePhase (bytePhase),
    .protSpace (protSpace),
    .e2Level   (e2Level),
    .e1Level   (e1Level),
    .e0HighV   (e0HighV),
    .ceMatch   (ceMatch),
    .rwBit     (rwBit),
    .targetAddr(targetAddr),
    .wcLevel   (wcLevel),
    .stopSeen  (stopSeen),
    .writeDone (writeDone),
    .lockQ     (lockQ),
    .armedQ    (armedQ),
    .busyQ     (busyQ),
    .strobe    (strobe)
  );

  wpLockRegs #(.PROT_INIT(PROT_INIT)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .lockQ    (lockQ),
    .armedQ   (armedQ),
    .busyQ    (busyQ),
    .ackValid (ackValid),
    .ackOut   (ackOut),
    .commitReq(commitReq)
  );

  assign protState = lockQ;

endmodule

// File: rtl/wpGuardChk.sv
module wpGuardChk (
  input logic       clk,
  input logic       rstN,
  input logic       byteValid,
  input logic [1:0] bytePhase,
  input logic       protSpace,
  input logic       rwBit,
  input logic       wcLevel,
  input logic       stopSeen,
  input logic       writeDone,
  input logic       ackValid,
  input logic       ackOut,
  input logic       commitReq,
  input logic [1:0] protState,
  input logic       busy
);

  // R2: a decision only appears in a qualified cycle right after a byte
  a_r2_ack_qualified: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> (ackValid && $past(byteValid)));

  // R3: write-control high refuses every write-form data byte
  a_r3_wc_blocks_data: assert property (@(posedge clk) disable iff (!rstN)
    $past(byteValid && wcLevel && bytePhase[1] && !rwBit) |-> !ackOut);

  // R7: hard lock is one-way
  a_r7_hard_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ($past(protState) == 2'b10) |-> (protState == 2'b10));

  // R7: hard lock refuses the protection space
  a_r7_hard_refuses: assert property (@(posedge clk) disable iff (!rstN)
    ($past(byteValid && protSpace) && $past(protState) == 2'b10) |-> !ackOut);

  // R9: a commit request is always caused by a stop
  a_r9_commit_after_stop: assert property (@(posedge clk) disable iff (!rstN)
    commitReq |-> $past(stopSeen));

  // R10: level moves only after a completion strobe
  a_r10_level_on_done: assert property (@(posedge clk) disable iff (!rstN)
    (protState != $past(protState)) |-> $past(writeDone));

  // R11: no acknowledge while a commit is outstanding
  a_r11_busy_silent: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy && byteValid) |-> !ackOut);

  // R11: no new commit while one is outstanding
  a_r11_no_double_commit: assert property (@(posedge clk) disable iff (!rstN)
    commitReq |-> !$past(busy));

endmodule

bind wpGuard wpGuardChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .byteValid (byteValid),
  .bytePhase (bytePhase),
  .protSpace (protSpace),
  .rwBit     (rwBit),
  .wcLevel   (wcLevel),
  .stopSeen  (stopSeen),
  .writeDone (writeDone),
  .ackValid  (ackValid),
  .ackOut    (ackOut),
  .commitReq (commitReq),
  .protState (protState),
  .busy      (busyQ)
);

// File: tb/wpGuard_tb.sv
`timescale 1ns/1ps
module wpGuard_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       byteValid = 1'b0;
  logic [1:0] bytePhase = 2'd0;
  logic       protSpace = 1'b0;
  logic       e2Level = 1'b0;
  logic       e1Level = 1'b0;
  logic       e0HighV = 1'b0;
  logic       ceMatch = 1'b0;
  logic       rwBit = 1'b0;
  logic [7:0] targetAddr = 8'h00;
  logic       wcLevel = 1'b0;
  logic       stopSeen = 1'b0;
  logic       writeDone = 1'b0;
  logic       ackValid;
  logic       ackOut;
  logic       commitReq;
  logic [1:0] protState;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  wpGuard #(.ADDR_W(8), .PROT_INIT(2'b00)) u_dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .bytePhase(bytePhase),
    .protSpace(protSpace), .e2Level(e2Level), .e1Level(e1Level),
    .e0HighV(e0HighV), .ceMatch(ceMatch), .rwBit(rwBit),
    .targetAddr(targetAddr), .wcLevel(wcLevel), .stopSeen(stopSeen),
    .writeDone(writeDone), .ackValid(ackValid), .ackOut(ackOut),
    .commitReq(commitReq), .protState(protState)
  );

  // ---------------- behavioural reference ----------------
  // levels: 0 unlocked, 1 soft, 2 hard; commands: 0 none, 1 set, 2 clear, 3 perm, 4 memory
  int  mLevel = 0;
  bit  mBusy = 0;
  bit  mArmed = 0;
  int  mOp = 0;
  bit  eAck = 0, eAckV = 0, eCommit = 0;

  function automatic int whichCmd(bit prot, bit e2, bit e1, bit hv, bit ce);
    if (!prot) return ce ? 4 : 0;
    if (hv) begin
      if (e2) return 0;
      return e1 ? 2 : 1;
    end
    return ce ? 3 : 0;
  endfunction

  function automatic bit judge(int lvl, int cmd, int ph, bit rw, bit wc, int addr);
    if (cmd == 0) return 0;
    if (cmd != 4 && lvl == 2) return 0;
    if (cmd == 1 && lvl == 1) return 0;
    if (ph == 0) return 1;
    if (rw) return 0;
    if (ph == 1) return 1;
    if (wc) return 0;
    if (cmd == 4 && addr < 128 && lvl != 0) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mLevel = 0; mBusy = 0; mArmed = 0; mOp = 0;
      eAck = 0; eAckV = 0; eCommit = 0;
    end else begin
      bit wasBusy;
      int cmd;
      bit verdict;
      wasBusy = mBusy;
      cmd = whichCmd(protSpace, e2Level, e1Level, e0HighV, ceMatch);
      verdict = byteValid && !wasBusy &&
                judge(mLevel, cmd, bytePhase, rwBit, wcLevel, targetAddr);
      eAckV = byteValid;
      eAck = verdict;
      eCommit = stopSeen && !wasBusy && mArmed;
      if (writeDone && wasBusy) begin
        mBusy = 0;
        if (mLevel != 2) begin
          if (mOp == 1) mLevel = 1;
          else if (mOp == 2) mLevel = 0;
          else if (mOp == 3) mLevel = 2;
        end
      end
      if (eCommit) mBusy = 1;
      if (stopSeen || (byteValid && !wasBusy && bytePhase == 2'd0)) mArmed = 0;
      else if (byteValid && !wasBusy && bytePhase >= 2 && !rwBit) begin
        mArmed = verdict;
        mOp = (cmd == 4) ? 0 : cmd;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      nChecks++;
      if (ackValid !== eAckV || ackOut !== eAck) begin
        nFails++;
        $display("FAIL R2 per-cycle ack: act v=%0b a=%0b exp v=%0b a=%0b",
                 ackValid, ackOut, eAckV, eAck);
      end
      nChecks++;
      if (commitReq !== eCommit) begin
        nFails++;
        $display("FAIL R9 per-cycle commit: act %0b exp %0b", commitReq, eCommit);
      end
      nChecks++;
      if (protState !== mLevel[1:0]) begin
        nFails++;
        $display("FAIL R10 per-cycle level: act %0d exp %0d", protState, mLevel);
      end
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired: act %0d cycles exp below 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: act %0d exp %0d", tag, act, exp);
    end
  endtask

  task automatic setCmd(input bit prot, input bit e2, input bit e1, input bit hv,
                        input bit ce, input bit rw, input bit wc);
    protSpace = prot; e2Level = e2; e1Level = e1; e0HighV = hv;
    ceMatch = ce; rwBit = rw; wcLevel = wc;
  endtask

  task automatic useSet(input bit wc);  setCmd(1, 0, 0, 1, 0, 0, wc); endtask
  task automatic useClr(input bit wc);  setCmd(1, 0, 1, 1, 0, 0, wc); endtask
  task automatic usePerm(input bit wc); setCmd(1, 0, 0, 0, 1, 0, wc); endtask
  task automatic useMem(input bit ce, input bit wc); setCmd(0, 0, 0, 0, ce, 0, wc); endtask

  task automatic sendByte(input int ph, input int addr, output bit a);
    @(negedge clk);
    bytePhase = ph[1:0];
    targetAddr = addr[7:0];
    byteValid = 1'b1;
    @(negedge clk);
    a = ackOut;
    byteValid = 1'b0;
  endtask

  task automatic triple(input int addr, output int pattern);
    bit a0, a1, a2;
    sendByte(0, 0, a0);
    sendByte(1, addr, a1);
    sendByte(2, addr, a2);
    pattern = {29'd0, a0, a1, a2};
  endtask

  task automatic doStop(output bit c);
    @(negedge clk);
    stopSeen = 1'b1;
    @(negedge clk);
    c = commitReq;
    stopSeen = 1'b0;
  endtask

  task automatic doDone();
    @(negedge clk);
    writeDone = 1'b1;
    @(negedge clk);
    writeDone = 1'b0;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int p;
    bit c, a;
    repeat (3) @(negedge clk);
    chk(protState == 2'b00 && !ackOut && !ackValid && !commitReq, "R1 reset outputs",
        {ackValid, ackOut, commitReq, protState}, 0);
    rstN = 1'b1;

    // memory write, unlocked
    useMem(1, 0);
    triple(8'h10, p); chk(p == 3'b111, "R2 memory write acks", p, 3'b111);
    doStop(c);        chk(c == 1, "R9 commit after acked data", c, 1);
    chk(protState == 2'b00, "R10 memory commit keeps level", protState, 0);
    doDone();

    useMem(0, 0);
    triple(8'h20, p); chk(p == 3'b000, "R2 no chip-enable match", p, 0);
    doStop(c);        chk(c == 0, "R9 no commit when refused", c, 0);

    useMem(1, 1);
    triple(8'h90, p); chk(p == 3'b110, "R3 wc high memory data", p, 3'b110);
    doStop(c);        chk(c == 0, "R3 no commit with wc high", c, 0);

    useSet(1);
    triple(8'h00, p); chk(p == 3'b110, "R5 unlocked set with wc high", p, 3'b110);
    doStop(c);        chk(c == 0, "R3 protection no commit wc high", c, 0);

    useSet(0);
    triple(8'h00, p); chk(p == 3'b111, "R5 unlocked set wc low", p, 3'b111);
    doStop(c);        chk(c == 1, "R5 set commit requested", c, 1);
    chk(protState == 2'b00, "R10 level unchanged at stop", protState, 0);
    useMem(1, 0);
    sendByte(0, 0, a); chk(a == 0, "R11 select refused while busy", a, 0);
    doStop(c);         chk(c == 0, "R11 stop during commit ignored", c, 0);
    doDone();
    chk(protState == 2'b01, "R10 set lands soft lock", protState, 1);

    // soft lock
    useMem(1, 0);
    triple(8'h05, p); chk(p == 3'b110, "R4 low half refused in soft lock", p, 3'b110);
    doStop(c);        chk(c == 0, "R4 no commit for refused low write", c, 0);
    triple(8'h85, p); chk(p == 3'b111, "R4 high half accepted", p, 3'b111);
    doStop(c);        chk(c == 1, "R9 high half commit", c, 1);
    doDone();

    useSet(0);
    triple(8'h00, p); chk(p == 3'b000, "R6 set refused in soft lock", p, 0);
    setCmd(1, 0, 0, 1, 0, 1, 0);
    sendByte(0, 0, a); chk(a == 0, "R8 read-form set select refused", a, 0);
    setCmd(1, 0, 1, 1, 0, 1, 0);
    sendByte(0, 0, a); chk(a == 1, "R8 read-form clear select accepted", a, 1);
    sendByte(2, 0, a); chk(a == 0, "R8 read-form later byte refused", a, 0);
    doStop(c);         chk(c == 0, "R9 no commit after read", c, 0);

    setCmd(1, 1, 0, 1, 0, 0, 0);
    sendByte(0, 0, a); chk(a == 0, "R12 high-V with top pin high", a, 0);
    setCmd(1, 0, 0, 0, 0, 0, 0);
    sendByte(0, 0, a); chk(a == 0, "R12 no high-V and no match", a, 0);

    useClr(1);
    triple(8'h00, p); chk(p == 3'b110, "R6 clear with wc high", p, 3'b110);
    doStop(c);        chk(c == 0, "R6 no commit with wc high", c, 0);
    useClr(0);
    triple(8'h00, p); chk(p == 3'b111, "R6 clear with wc low", p, 3'b111);
    doStop(c);        chk(c == 1, "R6 clear commit", c, 1);
    doDone();
    chk(protState == 2'b00, "R10 clear lands unlocked", protState, 0);

    useMem(1, 0);
    sendByte(0, 0, a);
    sendByte(1, 8'h30, a);
    doStop(c);        chk(c == 0, "R9 stop after address only", c, 0);

    usePerm(0);
    triple(8'h00, p); chk(p == 3'b111, "R5 unlocked permanent lock", p, 3'b111);
    doStop(c);        chk(c == 1, "R5 permanent commit", c, 1);
    doDone();
    chk(protState == 2'b10, "R10 permanent lands hard lock", protState, 2);

    // hard lock
    for (int w = 0; w < 2; w++) begin
      usePerm(w[0]); triple(8'h00, p); chk(p == 0, "R7 perm refused in hard lock", p, 0);
      useClr(w[0]);  triple(8'h00, p); chk(p == 0, "R7 clear refused in hard lock", p, 0);
      useSet(w[0]);  triple(8'h00, p); chk(p == 0, "R7 set refused in hard lock", p, 0);
      doStop(c);     chk(c == 0, "R7 no commit in hard lock", c, 0);
    end
    setCmd(1, 0, 1, 1, 0, 1, 0);
    sendByte(0, 0, a); chk(a == 0, "R8 read-form clear refused in hard lock", a, 0);
    useMem(1, 0);
    triple(8'h7F, p); chk(p == 3'b110, "R4 low half refused in hard lock", p, 3'b110);
    triple(8'h80, p); chk(p == 3'b111, "R4 boundary 80h accepted", p, 3'b111);
    doStop(c);        chk(c == 1, "R9 commit for last acked byte", c, 1);
    doDone();
    setCmd(0, 0, 0, 0, 1, 1, 0);
    sendByte(0, 0, a); chk(a == 1, "R8 memory read select", a, 1);
    sendByte(2, 0, a); chk(a == 0, "R8 memory read data byte", a, 0);
    doDone();
    @(negedge clk);
    chk(protState == 2'b10, "R10 idle done leaves level", protState, 2);
    chk(protState == 2'b10, "R7 hard lock persists", protState, 2);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule